// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a slower line-oriented main memory. It accepts one byte read or byte write at a time on a 16-bit byte address. It answers from its own storage when the addressed line is resident. Otherwise it moves whole 8-byte lines to and from memory over a simple request/acknowledge line port. Each of the 256 sets holds two lines. Every line carries a tag, a valid flag, a dirty flag and a small usage counter.

Stores stay in the cache until the line has to make room for another, so memory sees a line write only on eviction of a modified line. A store that misses first brings the line in and then completes as a store hit. The victim is chosen by usage counters. An access zeroes its own counter and ages the counters in the set that were younger than it, and the oldest line is replaced. An empty way is always filled before any resident line is displaced.

Top module: `cache2w_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready`=1, `resp_valid`=0 and `mem_req`=0. Reset empties every line and drops its dirty state: after reset, any access misses, and a line written before reset is never sent to memory.
- R2: The byte address is split as tag = bits 15:11, set = bits 10:3 and byte offset = bits 2:0. An access hits when a valid way of the set holds the same tag, and a read returns the byte at the offset within the line.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. A hit is answered in the cycle after the next edge, with `resp_hit`=1. `resp_valid` is a one-cycle pulse.
- R4: A write hit changes only the cached byte and marks the line dirty. It causes no memory traffic, and later reads return the new byte.
- R5: On a miss the whole line is fetched with `mem_we`=0 and `mem_addr` = {tag, set}. Byte i of a line occupies bits 8i+7:8i of `mem_rline`/`mem_wline`. The response, with `resp_hit`=0, comes only after the fetch is acknowledged.
- R6: A write miss allocates: the line is fetched, then the byte is written into it and the line becomes dirty.
- R7: If a way of the set is empty, a miss fills it and leaves the resident line in place.
- R8: Each access zeroes the accessed line's counter and increments the counters in the set that were below its old value. A miss in a full set replaces the line with the highest count, which is the least recently used one.
- R9: A dirty victim is written to memory before the fill, with `mem_we`=1, its own {tag, set} and its full line contents. A clean victim is dropped without a memory write.
- R10: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`. The cache is never ready for a new request while it has memory traffic outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = byte store, 0 = byte load |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Cache idle, request can be taken |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Request was served without a line fill |
| resp_rdata | output | 8 | Load data (byte after the store for writes) |
| mem_req | output | 1 | Line transfer request to memory |
| mem_we | output | 1 | 1 = write back line, 0 = fetch line |
| mem_addr | output | 13 | Line address {tag, set} |
| mem_wline | output | 64 | Line being written back |
| mem_rline | input | 64 | Fetched line, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the current transfer |

## Verification
A tag or valid bit that is wrong shows up on the next access to that set: the `resp_hit` flag differs and a fetch appears on the memory port, or stale data comes back one cycle after acceptance. A lost or spurious dirty bit stays hidden until the line is evicted. So the sequences age lines through several misses in one set and then inspect the memory contents and the write-back count. A counter that ages the wrong way only shows when a third tag arrives: the line that should have survived misses. The tests therefore revisit the line expected to survive right after each replacement.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_EVICT = 2'd2,
        ST_FILL  = 2'd3
    } cache_st_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
    parameter int TAG_W  = 5,
    parameter int SET_W  = 8,
    parameter int LINE_W = 64,
    parameter int CNT_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  set_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic              valid_o,
    output logic              dirty_o,
    output logic [LINE_W-1:0] line_o,
    output logic [CNT_W-1:0]  cnt_o,
    input  logic              line_we_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              meta_we_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              valid_i,
    input  logic              dirty_i,
    input  logic              cnt_we_i,
    input  logic [CNT_W-1:0]  cnt_i
);
    localparam int SETS = 1 << SET_W;

    logic [LINE_W-1:0] line_mem [SETS];
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [CNT_W-1:0]  cnt_mem  [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    // payload arrays carry no reset; the valid flag guards them
    always_ff @(posedge clk) begin
        if (line_we_i) line_mem[set_i] <= line_i;
        if (meta_we_i) tag_mem[set_i]  <= tag_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SETS; s++) cnt_mem[s] <= '0;
        end else begin
            if (meta_we_i) begin
                valid_q[set_i] <= valid_i;
                dirty_q[set_i] <= dirty_i;
            end
            if (cnt_we_i) cnt_mem[set_i] <= cnt_i;
        end
    end

    assign tag_o   = tag_mem[set_i];
    assign valid_o = valid_q[set_i];
    assign dirty_o = dirty_q[set_i];
    assign line_o  = line_mem[set_i];
    assign cnt_o   = cnt_mem[set_i];
endmodule

// File: rtl/cache2w_repl.sv
module cache2w_repl #(
    parameter int WAYS  = 2,
    parameter int CNT_W = 1,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][CNT_W-1:0] cnt_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAY_W-1:0]           acc_i,
    output logic [WAY_W-1:0]           victim_o,
    output logic [WAYS-1:0][CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] acc_cnt;
    assign acc_cnt = cnt_i[acc_i];

    // victim: first empty way, else the oldest (lowest index on a tie)
    always_comb begin
        logic             have_empty;
        logic [CNT_W-1:0] oldest;
        have_empty = 1'b0;
        victim_o   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_i[w] && !have_empty) begin
                have_empty = 1'b1;
                victim_o   = WAY_W'(w);
            end
        end
        oldest = cnt_i[0];
        if (!have_empty) begin
            for (int w = 1; w < WAYS; w++) begin
                if (cnt_i[w] > oldest) begin
                    oldest   = cnt_i[w];
                    victim_o = WAY_W'(w);
                end
            end
        end
    end

    // aging after an access to way acc_i
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (acc_i == WAY_W'(w))
                cnt_o[w] = '0;
            else if (cnt_i[w] < acc_cnt)
                cnt_o[w] = cnt_i[w] + CNT_W'(1);
            else
                cnt_o[w] = cnt_i[w];
        end
    end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int SET_W  = 8,
    parameter int OFS_W  = 3,
    parameter int DATA_W = 8,
    parameter int WAYS   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [TAG_W+SET_W+OFS_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]                  req_wdata,
    output logic                               req_ready,
    output logic                               resp_valid,
    output logic                               resp_hit,
    output logic [DATA_W-1:0]                  resp_rdata,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [TAG_W+SET_W-1:0]             mem_addr,
    output logic [(DATA_W<<OFS_W)-1:0]         mem_wline,
    input  logic [(DATA_W<<OFS_W)-1:0]         mem_rline,
    input  logic                               mem_ack
);
    localparam int LINE_W = DATA_W << OFS_W;
    localparam int CNT_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int WAY_W  = CNT_W;
    localparam logic [CNT_W-1:0] CNT_OLDEST = CNT_W'(WAYS - 1);

    typedef struct packed {
        cache_st_e          st;
        logic [TAG_W-1:0]   tag;
        logic [SET_W-1:0]   set;
        logic [OFS_W-1:0]   ofs;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
        logic               missed;
        logic [WAY_W-1:0]   way;
        logic               rsp_v;
        logic               rsp_hit;
        logic [DATA_W-1:0]  rsp_data;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    // per-way storage view of the current set
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0]             way_dirty;
    logic [WAYS-1:0][LINE_W-1:0] way_line;
    logic [WAYS-1:0][CNT_W-1:0]  way_cnt;

    // write controls
    logic [WAYS-1:0]             line_we;
    logic [LINE_W-1:0]           line_wr;
    logic [WAYS-1:0]             meta_we;
    logic                        meta_dirty;
    logic [WAYS-1:0]             cnt_we;
    logic [WAYS-1:0][CNT_W-1:0]  cnt_wr;

    // lookup results
    logic [WAYS-1:0]             way_hit;
    logic                        any_hit;
    logic [WAY_W-1:0]            hit_idx;
    logic [WAY_W-1:0]            victim;
    logic [WAYS-1:0][CNT_W-1:0]  aged_cnt;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache2w_way #(
            .TAG_W (TAG_W),
            .SET_W (SET_W),
            .LINE_W(LINE_W),
            .CNT_W (CNT_W)
        ) i_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (ctrl_q.set),
            .tag_o    (way_tag[w]),
            .valid_o  (way_valid[w]),
            .dirty_o  (way_dirty[w]),
            .line_o   (way_line[w]),
            .cnt_o    (way_cnt[w]),
            .line_we_i(line_we[w]),
            .line_i   (line_wr),
            .meta_we_i(meta_we[w]),
            .tag_i    (ctrl_q.tag),
            .valid_i  (1'b1),
            .dirty_i  (meta_dirty),
            .cnt_we_i (cnt_we[w]),
            .cnt_i    (cnt_wr[w])
        );
        assign way_hit[w] = way_valid[w] && (way_tag[w] == ctrl_q.tag);
    end

    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                any_hit = 1'b1;
                hit_idx = WAY_W'(w);
            end
        end
    end

    cache2w_repl #(
        .WAYS (WAYS),
        .CNT_W(CNT_W),
        .WAY_W(WAY_W)
    ) i_repl (
        .cnt_i   (way_cnt),
        .valid_i (way_valid),
        .acc_i   (hit_idx),
        .victim_o(victim),
        .cnt_o   (aged_cnt)
    );

    always_comb begin
        logic [LINE_W-1:0] merged;
        ctrl_d     = ctrl_q;
        ctrl_d.rsp_v = 1'b0;
        line_we    = '0;
        line_wr    = mem_rline;
        meta_we    = '0;
        meta_dirty = 1'b0;
        cnt_we     = '0;
        cnt_wr     = aged_cnt;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {ctrl_q.tag, ctrl_q.set};
        mem_wline  = way_line[ctrl_q.way];
        merged     = way_line[hit_idx];
        merged[ctrl_q.ofs*DATA_W +: DATA_W] = ctrl_q.wdata;

        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.st     = ST_LOOK;
                    ctrl_d.tag    = req_addr[OFS_W+SET_W +: TAG_W];
                    ctrl_d.set    = req_addr[OFS_W +: SET_W];
                    ctrl_d.ofs    = req_addr[OFS_W-1:0];
                    ctrl_d.wr     = req_write;
                    ctrl_d.wdata  = req_wdata;
                    ctrl_d.missed = 1'b0;
                end
            end
            ST_LOOK: begin
                if (any_hit) begin
                    cnt_we = '1;
                    if (ctrl_q.wr) begin
                        line_we[hit_idx] = 1'b1;
                        line_wr          = merged;
                        meta_we[hit_idx] = 1'b1;
                        meta_dirty       = 1'b1;
                        ctrl_d.rsp_data  = ctrl_q.wdata;
                    end else begin
                        ctrl_d.rsp_data  = way_line[hit_idx][ctrl_q.ofs*DATA_W +: DATA_W];
                    end
                    ctrl_d.rsp_v   = 1'b1;
                    ctrl_d.rsp_hit = !ctrl_q.missed;
                    ctrl_d.st      = ST_IDLE;
                end else begin
                    ctrl_d.missed = 1'b1;
                    ctrl_d.way    = victim;
                    ctrl_d.st     = (way_valid[victim] && way_dirty[victim]) ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {way_tag[ctrl_q.way], ctrl_q.set};
                if (mem_ack) ctrl_d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    line_we[ctrl_q.way] = 1'b1;
                    meta_we[ctrl_q.way] = 1'b1;
                    cnt_we[ctrl_q.way]  = 1'b1;
                    cnt_wr[ctrl_q.way]  = CNT_OLDEST;
                    ctrl_d.st           = ST_LOOK;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign req_ready  = (ctrl_q.st == ST_IDLE);
    assign resp_valid = ctrl_q.rsp_v;
    assign resp_hit   = ctrl_q.rsp_hit;
    assign resp_rdata = ctrl_q.rsp_data;
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int LADDR_W = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               mem_req,
    input logic               mem_we,
    input logic [LADDR_W-1:0] mem_addr,
    input logic               mem_ack
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !resp_valid && !mem_req));

    // R3
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $past(req_valid && req_ready, 2));

    // R5
    miss_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(mem_ack && mem_req && !mem_we, 2));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_req));
endmodule

bind cache2w_ctrl cache2w_chk #(
    .LADDR_W(TAG_W + SET_W)
) i_cache2w_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .resp_valid(resp_valid),
    .resp_hit  (resp_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/test_cache2w_ctrl.sv
`timescale 1ns/1ps
module test_cache2w_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, resp_valid, resp_hit;
    logic [7:0]  resp_rdata;
    logic        mem_req, mem_we;
    logic [12:0] mem_addr;
    logic [63:0] mem_wline;
    logic [63:0] mem_rline = '0;
    logic        mem_ack = 1'b0;

    cache2w_ctrl i_cache2w_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
        .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         rq;
        logic [7:0] data;
        logic       hit;
        int         acc;
    } exp_t;
    exp_t exp_q[$];

    logic [63:0] mem_lines [int];
    logic [7:0]  shadow [int];

    function automatic logic [7:0] init_byte(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
    endfunction

    function automatic logic [63:0] mem_get(input logic [12:0] la);
        logic [63:0] l;
        if (mem_lines.exists(int'(la))) return mem_lines[int'(la)];
        for (int i = 0; i < 8; i++) l[i*8 +: 8] = init_byte({la, 3'(i)});
        return l;
    endfunction

    function automatic logic [7:0] shadow_get(input logic [15:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return init_byte(a);
    endfunction

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // main-memory model: fixed latency, one-cycle acknowledge
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(posedge clk);
            if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (lat == 2) begin
                    lat = 0;
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        mem_lines[int'(mem_addr)] = mem_wline;
                        wr_cnt++;
                    end else begin
                        mem_rline <= mem_get(mem_addr);
                        rd_cnt++;
                    end
                end else begin
                    lat++;
                end
            end
        end
    end

    // monitor: compare every response against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, 3, "unexpected response", 64'(resp_rdata), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(resp_rdata == e.data, e.rq, "data", 64'(resp_rdata), 64'(e.data));
                    check(resp_hit == e.hit, e.rq, "hit flag", 64'(resp_hit), 64'(e.hit));
                    if (e.hit)  // R3 hit answered one cycle after the accepting edge's successor
                        check(cyc == e.acc + 1, 3, "hit latency", 64'(cyc), 64'(e.acc + 1));
                end
            end
        end
    end

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                          input bit exp_hit, input int rq);
        exp_t e;
        logic [7:0] ed;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (wr) begin
            shadow[int'(a)] = wd;
            ed = wd;
        end else begin
            ed = shadow_get(a);
        end
        e.rq = rq; e.data = ed; e.hit = exp_hit; e.acc = cyc + 1;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, input bit h, input int rq);
        access(1'b0, a, 8'h00, h, rq);
    endtask

    initial begin
        int w0, r0;
        logic [63:0] ln;
        repeat (3) @(negedge clk);
        // R1 ports while reset is held
        check(req_ready && !resp_valid && !mem_req, 1, "idle during reset",
              {req_ready, resp_valid, mem_req}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_req, 1, "idle after reset",
              {req_ready, resp_valid, mem_req}, 3'b100);

        // R5 read miss fills one line; R2 tag 0, set 0x24, offset 3
        r0 = rd_cnt;
        rd(16'h0123, 1'b0, 5);
        check(rd_cnt == r0 + 1, 5, "one line fetch on miss", rd_cnt, r0 + 1);
        rd(16'h0125, 1'b1, 2);                 // R2 same line, other offset
        w0 = wr_cnt; r0 = rd_cnt;
        access(1'b1, 16'h0126, 8'hA5, 1'b1, 4); // R4 write hit
        rd(16'h0126, 1'b1, 4);
        check(wr_cnt == w0 && rd_cnt == r0, 4, "no memory traffic on write hit",
              wr_cnt + rd_cnt, w0 + r0);
        // R7 second tag goes to the empty way, first stays resident
        rd(16'h0923, 1'b0, 7);
        rd(16'h0120, 1'b1, 7);
        // R8 tag1 is now oldest: tag2 replaces it, tag0 survives
        rd(16'h1123, 1'b0, 8);
        check(wr_cnt == w0, 9, "clean victim not written", wr_cnt, w0);
        rd(16'h0126, 1'b1, 8);
        rd(16'h0923, 1'b0, 8);                 // R8 evicts tag2
        check(wr_cnt == w0, 9, "clean victim not written", wr_cnt, w0);
        // R9 tag0 (dirty) is oldest now and is written back
        rd(16'h1120, 1'b0, 9);
        check(wr_cnt == w0 + 1, 9, "dirty victim written back", wr_cnt, w0 + 1);
        ln = mem_get(13'h0024);
        check(ln[6*8 +: 8] == 8'hA5, 9, "written-back byte 6", 64'(ln[6*8 +: 8]), 64'hA5);
        check(ln[3*8 +: 8] == init_byte(16'h0123), 9, "written-back byte 3",
              64'(ln[3*8 +: 8]), 64'(init_byte(16'h0123)));
        rd(16'h0126, 1'b0, 8);                 // R8 refetch evicts tag1, data from memory
        // R6 write miss allocates then writes
        r0 = rd_cnt;
        access(1'b1, 16'h2040, 8'h3C, 1'b0, 6);
        check(rd_cnt == r0 + 1, 6, "line fetched on write miss", rd_cnt, r0 + 1);
        rd(16'h2040, 1'b1, 6);
        rd(16'h2041, 1'b1, 6);
        // R2 last offset and first offset of the top line
        rd(16'hFFFF, 1'b0, 2);
        rd(16'hFFF8, 1'b1, 2);

        // R1 reset mid-run drops contents and dirty state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_req, 1, "idle after second reset",
              {req_ready, resp_valid, mem_req}, 3'b100);
        w0 = wr_cnt;
        rd(16'h0125, 1'b0, 1);
        shadow.delete(int'(16'h2040));        // dirty byte was never written back
        rd(16'h2040, 1'b0, 1);
        check(wr_cnt == w0, 1, "no write-back of pre-reset dirty line", wr_cnt, w0);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule